// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block conditions the second operand of an ALU in the same cycle that the ALU consumes it. It is purely combinational. A 32-bit operand enters together with a shift kind, a shift amount and the current carry flag. The block returns the shifted operand and the carry bit that the shift produced, so that a flag-setting logical operation can report it. The amount comes from one of two places. It can be a 5-bit immediate taken from the instruction, or the low byte of a register value.

The supported kinds are a logical left shift, a logical right shift, an arithmetic right shift, a rotate right, and a one-place rotate right through the carry flag. Any amount that resolves to zero returns the operand unchanged and passes the incoming carry straight through. Register amounts can exceed the word width. Each kind then saturates or wraps in its own defined way, so software never sees an undefined result.

The block has no clock and no storage. Because it sits directly on the ALU's operand path, it has no valid/ready handshake and no back-pressure: every output depends only on the inputs present in the same cycle.

Top module: `op2_barrel_shifter`

## Requirements
- R1: With `shift_kind` = 0 (logical left) and an effective amount n from 1 to 31, `shift_out` is `opnd_in` shifted left by n places with zeros entering at bit 0, and `carry_out` is `opnd_in[32-n]`. For n = 32, the output is zero and the carry is `opnd_in[0]`.
- R2: With `shift_kind` = 1 (logical right) and n from 1 to 32, `shift_out` is `opnd_in` shifted right by n places with zeros entering at bit 31, and `carry_out` is `opnd_in[n-1]`.
- R3: With `shift_kind` = 2 (arithmetic right) and n from 1 to 31, vacated high bits are copies of `opnd_in[31]` and `carry_out` is `opnd_in[n-1]`. For any n of 32 or more, every output bit and `carry_out` equal `opnd_in[31]`.
- R4: With `shift_kind` = 3 (rotate right), the operand is rotated right by n modulo 32 places and `carry_out` equals the new bit 31. A nonzero n that is a multiple of 32 returns the operand unchanged, with `carry_out` = `opnd_in[31]`.
- R5: With `shift_kind` = 4 (rotate through carry), the amount inputs are ignored. `shift_out` = {`carry_in`, `opnd_in[31:1]`} and `carry_out` = `opnd_in[0]`.
- R6: For kinds 0 to 3, an effective amount of zero gives `shift_out` = `opnd_in` and `carry_out` = `carry_in`. The unused kind codes 5 to 7 behave the same way for every amount.
- R7: When the amount comes from the register, only `reg_amt[7:0]` is used. Bits 31 to 8 have no effect on either output.
- R8: For kinds 0 and 1, a register amount of 33 to 255 gives `shift_out` = 0 and `carry_out` = 0.
- R9: `amt_from_reg` = 0 selects the 5-bit unsigned `imm_amt` as the amount, and `reg_amt` is then ignored. `amt_from_reg` = 1 selects the register amount, and `imm_amt` is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_in | input | 32 | Operand to be shifted |
| shift_kind | input | 3 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 32 | Register value whose low byte is the amount |
| amt_from_reg | input | 1 | 1 selects the register amount, 0 the immediate |
| carry_in | input | 1 | Current carry flag |
| shift_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bound checker tests the following whenever an input changes:
- zero-amount pass-through, including carry forwarding;
- the exact rotate-through-carry result;
- zero fill at the vacated end of the logical shifts;
- sign preservation of the arithmetic shift;
- the bit-count invariance of rotation;
- the cleared result of over-range logical shifts.

These properties cannot pin down which bit becomes the carry at each amount. Nor can they show that high register bits or the unselected amount source are ignored. The bench's scenarios, run against a step-by-step reference model, cover these cases, sweeping every kind across amounts 0 to 40 and the 255 limit.

// File: rtl/op2sh_pkg.sv
package op2sh_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/op2sh_amount.sv
module op2sh_amount #(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  parameter int IMM_W     = $clog2(DATA_W),
  parameter int SH_W      = $clog2(DATA_W) + 1
) (
  input  logic [IMM_W-1:0]     imm_amt,
  input  logic [DATA_W-1:0]    reg_amt,
  input  logic                 from_reg,
  output logic                 is_zero,
  output logic                 above_w,
  output logic [IMM_W-1:0]     low_bits,
  output logic [SH_W-1:0]      sat
);
  logic [REG_AMT_W-1:0] amt;
  logic                 at_least_w;

  always_comb begin
    amt        = from_reg ? reg_amt[REG_AMT_W-1:0] : REG_AMT_W'(imm_amt);
    is_zero    = (amt == '0);
    above_w    = (amt >  REG_AMT_W'(DATA_W));
    at_least_w = (amt >= REG_AMT_W'(DATA_W));
    low_bits   = amt[IMM_W-1:0];
    sat        = at_least_w ? SH_W'(DATA_W) : SH_W'(amt);
  end
endmodule

// File: rtl/op2sh_bitrev.sv
module op2sh_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/op2sh_funnel.sv
module op2sh_funnel #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  input  logic [SH_W-1:0]   n,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int VW = 2 * DATA_W + 1;

  logic [VW-1:0] stage [SH_W+1];

  assign stage[0] = {hi, lo, 1'b0};

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    assign stage[i+1] = n[i] ? (stage[i] >> (2 ** i)) : stage[i];
  end

  assign res  = stage[SH_W][DATA_W:1];
  assign cout = stage[SH_W][0];
endmodule

// File: rtl/op2_barrel_shifter.sv
module op2_barrel_shifter
  import op2sh_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]         opnd_in,
  input  logic [2:0]                shift_kind,
  input  logic [$clog2(DATA_W)-1:0] imm_amt,
  input  logic [DATA_W-1:0]         reg_amt,
  input  logic                      amt_from_reg,
  input  logic                      carry_in,
  output logic [DATA_W-1:0]         shift_out,
  output logic                      carry_out
);
  localparam int IMM_W = $clog2(DATA_W);
  localparam int SH_W  = IMM_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic              amt_zero, amt_above;
  logic [IMM_W-1:0]  amt_low;
  logic [SH_W-1:0]   amt_sat;
  logic [DATA_W-1:0] x_rev, fun_lo, fun_hi, fun_res, res_rev;
  logic [SH_W-1:0]   fun_n;
  logic              fun_c;
  logic              use_rev;
  shift_kind_e       kind;

  op2sh_amount #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_amt (
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .from_reg(amt_from_reg),
    .is_zero (amt_zero),
    .above_w (amt_above),
    .low_bits(amt_low),
    .sat     (amt_sat)
  );

  op2sh_bitrev #(.W(DATA_W)) u_rev_in  (.din(opnd_in), .dout(x_rev));
  op2sh_bitrev #(.W(DATA_W)) u_rev_out (.din(fun_res), .dout(res_rev));

  op2sh_funnel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_fun (
    .hi  (fun_hi),
    .lo  (fun_lo),
    .n   (fun_n),
    .res (fun_res),
    .cout(fun_c)
  );

  // Left shift runs on the right funnel through bit reversal.
  always_comb begin
    kind    = shift_kind_e'(shift_kind);
    use_rev = (kind == SK_LSL);
    fun_lo  = use_rev ? x_rev : opnd_in;
    fun_hi  = '0;
    fun_n   = amt_sat;
    case (kind)
      SK_ASR: fun_hi = {DATA_W{opnd_in[MSB]}};
      SK_ROR: begin
        fun_hi = opnd_in;
        fun_n  = SH_W'(amt_low);
      end
      SK_RRX: begin
        fun_hi = DATA_W'(carry_in);
        fun_n  = SH_W'(1);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (shift_kind > 3'(SK_RRX)) begin
      shift_out = opnd_in;
      carry_out = carry_in;
    end else if (kind != SK_RRX && amt_zero) begin
      shift_out = opnd_in;
      carry_out = carry_in;
    end else if (kind == SK_ROR && amt_low == '0) begin
      shift_out = opnd_in;
      carry_out = opnd_in[MSB];
    end else if ((kind == SK_LSL || kind == SK_LSR) && amt_above) begin
      shift_out = '0;
      carry_out = 1'b0;
    end else begin
      shift_out = use_rev ? res_rev : fun_res;
      carry_out = fun_c;
    end
  end
endmodule

// File: rtl/op2sh_checker.sv
module op2sh_checker #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0]         opnd_in,
  input logic [2:0]                shift_kind,
  input logic [$clog2(DATA_W)-1:0] imm_amt,
  input logic [DATA_W-1:0]         reg_amt,
  input logic                      amt_from_reg,
  input logic                      carry_in,
  input logic [DATA_W-1:0]         shift_out,
  input logic                      carry_out
);
  logic [7:0] eff;
  assign eff = amt_from_reg ? reg_amt[7:0] : 8'(imm_amt);

  always_comb begin
    if (shift_kind < 3'd4 && eff == 8'd0)
      assert_zero_pass_R6: assert (shift_out == opnd_in && carry_out == carry_in);
    if (shift_kind == 3'd4)
      assert_rrx_R5: assert (shift_out == {carry_in, opnd_in[DATA_W-1:1]} && carry_out == opnd_in[0]);
    if (shift_kind == 3'd0 && eff != 8'd0)
      assert_lsl_fill_R1: assert (shift_out[0] == 1'b0);
    if (shift_kind == 3'd1 && eff != 8'd0)
      assert_lsr_fill_R2: assert (shift_out[DATA_W-1] == 1'b0);
    if (shift_kind == 3'd2)
      assert_asr_sign_R3: assert (shift_out[DATA_W-1] == opnd_in[DATA_W-1]);
    if (shift_kind == 3'd3)
      assert_ror_ones_R4: assert ($countones(shift_out) == $countones(opnd_in));
    if ((shift_kind == 3'd0 || shift_kind == 3'd1) && eff > 8'd32)
      assert_over_range_R8: assert (shift_out == '0 && carry_out == 1'b0);
  end
endmodule

bind op2_barrel_shifter op2sh_checker #(.DATA_W(DATA_W)) u_op2sh_checker (
  .opnd_in     (opnd_in),
  .shift_kind  (shift_kind),
  .imm_amt     (imm_amt),
  .reg_amt     (reg_amt),
  .amt_from_reg(amt_from_reg),
  .carry_in    (carry_in),
  .shift_out   (shift_out),
  .carry_out   (carry_out)
);

// File: tb/tb_op2_barrel_shifter.sv
`timescale 1ns/1ps
module tb_op2_barrel_shifter;
  logic        clk = 1'b0;
  logic [31:0] opnd_in = '0;
  logic [2:0]  shift_kind = '0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] reg_amt = '0;
  logic        amt_from_reg = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] shift_out;
  logic        carry_out;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  op2_barrel_shifter dut (
    .opnd_in(opnd_in), .shift_kind(shift_kind), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .amt_from_reg(amt_from_reg), .carry_in(carry_in),
    .shift_out(shift_out), .carry_out(carry_out)
  );

  // Step-by-step reference: one place per iteration.
  function automatic logic [32:0] ref_model(logic [31:0] x, logic [2:0] k,
      logic from_reg, logic [4:0] imm, logic [31:0] rg, logic cin);
    logic [31:0] r = x;
    logic        c = cin;
    int          a = from_reg ? int'(rg[7:0]) : int'(imm);
    if (k == 3'd4) begin
      c = x[0];
      r = {cin, x[31:1]};
    end else if (k < 3'd4) begin
      for (int s = 0; s < a; s++) begin
        case (k)
          3'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
          3'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
          3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
    return {c, r};
  endfunction

  task automatic apply_check(string tag, logic [31:0] x, logic [2:0] k,
      logic from_reg, logic [4:0] imm, logic [31:0] rg, logic cin);
    logic [32:0] exp;
    @(negedge clk);
    opnd_in = x; shift_kind = k; amt_from_reg = from_reg;
    imm_amt = imm; reg_amt = rg; carry_in = cin;
    #1;
    exp = ref_model(x, k, from_reg, imm, rg, cin);
    checks++;
    if ({carry_out, shift_out} !== exp) begin
      bad++;
      $display("FAIL %s: kind=%0d x=%h amt_sel=%0d imm=%0d reg=%h cin=%0b got out=%h c=%0b expected out=%h c=%0b",
               tag, k, x, from_reg, imm, rg, cin, shift_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  function automatic string kind_tag(int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic t_idle;
    apply_check("R6 idle", 32'h0, 3'd0, 1'b0, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_lsl_r1;
    apply_check("R1", 32'h8000_0001, 3'd0, 1'b0, 5'd1, 32'h0, 1'b0);
    apply_check("R1", 32'h0000_0008, 3'd0, 1'b0, 5'd3, 32'h0, 1'b1);
    apply_check("R1", 32'hFFFF_FFFF, 3'd0, 1'b0, 5'd31, 32'h0, 1'b0);
    apply_check("R1 n=32", 32'h0000_0001, 3'd0, 1'b1, 5'd0, 32'd32, 1'b0);
  endtask

  task automatic t_lsr_r2;
    apply_check("R2", 32'h0000_0008, 3'd1, 1'b0, 5'd2, 32'h0, 1'b0);
    apply_check("R2", 32'hFFFF_FFF8, 3'd1, 1'b0, 5'd2, 32'h0, 1'b0);
    apply_check("R2 n=32", 32'h8000_0000, 3'd1, 1'b1, 5'd0, 32'd32, 1'b0);
  endtask

  task automatic t_asr_r3;
    apply_check("R3", 32'hFFFF_FFF8, 3'd2, 1'b0, 5'd2, 32'h0, 1'b0);
    apply_check("R3", 32'h0000_0008, 3'd2, 1'b0, 5'd2, 32'h0, 1'b1);
    apply_check("R3 n=32", 32'h8000_1234, 3'd2, 1'b1, 5'd0, 32'd32, 1'b0);
    apply_check("R3 n=200", 32'h7000_1234, 3'd2, 1'b1, 5'd0, 32'd200, 1'b1);
  endtask

  task automatic t_ror_r4;
    apply_check("R4", 32'h0000_0013, 3'd3, 1'b0, 5'd5, 32'h0, 1'b0);
    apply_check("R4 n=32", 32'h8000_0010, 3'd3, 1'b1, 5'd0, 32'd32, 1'b0);
    apply_check("R4 n=37", 32'h0000_0013, 3'd3, 1'b1, 5'd0, 32'd37, 1'b0);
  endtask

  task automatic t_rrx_r5;
    apply_check("R5", 32'h0000_0003, 3'd4, 1'b0, 5'd9, 32'h0, 1'b1);
    apply_check("R5", 32'h8000_0002, 3'd4, 1'b1, 5'd0, 32'd77, 1'b0);
  endtask

  task automatic t_zero_r6;
    for (int k = 0; k < 8; k++) begin
      apply_check("R6", 32'hA5A5_0F0F, 3'(k), 1'b0, 5'd0, 32'h0, 1'b1);
    end
    apply_check("R6 unused", 32'h1234_5678, 3'd6, 1'b1, 5'd0, 32'd9, 1'b0);
  endtask

  task automatic t_upper_r7;
    apply_check("R7", 32'hF0F0_F0F1, 3'd1, 1'b1, 5'd0, 32'hFFFF_FF04, 1'b0);
    apply_check("R7", 32'hF0F0_F0F1, 3'd0, 1'b1, 5'd0, 32'h0000_0100, 1'b0);
  endtask

  task automatic t_over_r8;
    apply_check("R8", 32'hFFFF_FFFF, 3'd0, 1'b1, 5'd0, 32'd33, 1'b1);
    apply_check("R8", 32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0, 32'd255, 1'b1);
  endtask

  task automatic t_select_r9;
    apply_check("R9", 32'h0000_00F0, 3'd1, 1'b0, 5'd4, 32'd9, 1'b0);
    apply_check("R9", 32'h0000_00F0, 3'd1, 1'b1, 5'd4, 32'd9, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] pats [4] = '{32'h8000_0001, 32'hDEAD_BEEF, 32'h7FFF_FFFE, 32'h0F00_00F0};
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 5; k++) begin
        for (int a = 0; a <= 40; a++) begin
          apply_check(kind_tag(k), pats[p], 3'(k), 1'b1, 5'd0, 32'(a), p[0]);
        end
        apply_check(kind_tag(k), pats[p], 3'(k), 1'b1, 5'd0, 32'd255, p[1]);
        for (int a = 0; a < 32; a++) begin
          apply_check(kind_tag(k), pats[p], 3'(k), 1'b0, 5'(a), 32'hFFFF_FFFF, ~p[0]);
        end
      end
    end
  endtask

  initial begin
    t_idle();
    t_lsl_r1();
    t_lsr_r2();
    t_asr_r3();
    t_ror_r4();
    t_rrx_r5();
    t_zero_r6();
    t_upper_r7();
    t_over_r8();
    t_select_r9();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule